// File: doc/BRIEF.md
# Hardwired Hierarchical Statechart Controller

This block implements a small two-level statechart in fixed logic. At the top level, exactly one of two superstates runs at a time. The "active" superstate holds two concurrent leaf regions: a transmit region and a capture region. The "wait" superstate holds one leaf region that alternates between an idle state and a background state, and that region keeps shallow history. No logic exists for a superstate that only contains other regions. Each leaf region is its own clocked state machine with a registered activation bit. Hierarchy works only through events: the wait region raises an event when it accepts a wake, and the transmit region raises an event when it accepts a sleep. Its peers consume these events.

The transmit region runs a task that lasts several cycles. While the task runs, a run-to-completion latch holds any new request, and a second task starts as soon as the first one ends. A shared "work" output is driven by all three regions. It is merged as the OR, over regions, of each region's raw signal ANDed with that region's activation bit, so a region that is switched off contributes nothing. All inputs are single-cycle pulses sampled on the rising clock edge. Reset is synchronous.

Top module: `hsc_ctrl`

## Requirements
- R1: After reset, wait_on_o is 1, send_on_o and recv_on_o are 0, and wait_bg_o, tx_busy_o, tx_done_o, save_o and work_o are 0. The history value is "idle", so the first return to wait lands in idle.
- R2: A wake_i pulse while the wait region is on sets send_on_o and recv_on_o to 1 and wait_on_o to 0 from the next cycle. The transmit region starts ready and the capture region starts listening.
- R3: A sleep_i pulse while the active superstate runs clears send_on_o and recv_on_o and sets wait_on_o from the next cycle. A wake_i while active, or a sleep_i while waiting, has no effect.
- R4: Shallow history: when the wait region resumes on sleep, it returns to the state (idle or background) it left on the last wake. The history value is kept across any number of activations.
- R5: While the wait region is on, each bg_i pulse toggles between idle and background. wait_bg_o is 1 exactly while the region is on and in background. bg_i has no effect while the wait region is off.
- R6: A higher-level transition wins over a coincident lower-level one. wake_i together with bg_i leaves wait and records the state held before the toggle. sleep_i together with tx_req_i or rx_data_i leaves active, and no task or save starts.
- R7: tx_req_i while the transmit region is ready raises tx_busy_o from the next cycle for exactly TX_CYCLES cycles. tx_done_o is 1 only in the last of those cycles.
- R8: Run to completion: one or more tx_req_i pulses during a task (or in its last cycle) start exactly one further task right after the current one, with no idle cycle in between.
- R9: rx_data_i while the capture region is listening raises save_o for exactly one cycle, starting in the next cycle. rx_data_i in that save cycle is ignored.
- R10: work_o equals tx_busy_o OR save_o OR wait_bg_o. A background state remembered in history does not drive work_o while the active superstate runs.
- R11: A sleep_i during a task ends it at once and discards any latched request. After the next wake the transmit region is ready and idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wake_i | input | 1 | Wake event pulse (wait to active) |
| sleep_i | input | 1 | Sleep event pulse (active to wait) |
| bg_i | input | 1 | Background toggle event pulse |
| tx_req_i | input | 1 | Transmit task request pulse |
| rx_data_i | input | 1 | Capture event pulse |
| send_on_o | output | 1 | Transmit region activation bit |
| recv_on_o | output | 1 | Capture region activation bit |
| wait_on_o | output | 1 | Wait region activation bit |
| wait_bg_o | output | 1 | Wait region on and in background |
| tx_busy_o | output | 1 | Transmit task in progress |
| tx_done_o | output | 1 | Last cycle of a transmit task |
| save_o | output | 1 | Capture save cycle |
| work_o | output | 1 | Merged work signal from all regions |

## Verification
The bench builds the block with TX_CYCLES set to 4. A task that short lets a few directed cycles reach every case: a request landing in the last busy cycle, several requests stacked into one pending restart, and a sleep that cuts a task short with a request still latched. A behavioural model with integer counters runs alongside and is compared on every output in every cycle. After the directed phases, a long pseudo-random pulse stream makes wake, sleep, toggle and request events coincide in many orders.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

    typedef enum logic { SND_READY = 1'b0, SND_BUSY = 1'b1 } snd_st_e;

    typedef enum logic { RCV_LISTEN = 1'b0, RCV_SAVE = 1'b1 } rcv_st_e;

    typedef enum logic [1:0] {
        WT_IDLE  = 2'd0,
        WT_BG    = 2'd1,
        WT_ENTRY = 2'd2
    } wt_st_e;

    localparam int REG_SEND = 0;
    localparam int REG_RECV = 1;
    localparam int REG_WAIT = 2;
    localparam int NUM_REG  = 3;

endpackage

// File: rtl/hsc_wait_region.sv
module hsc_wait_region
    import hsc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wake_i,
    input  logic bg_i,
    input  logic to_wait_i,
    output logic on_o,
    output logic bg_raw_o,
    output logic to_active_o
);

    typedef struct packed {
        logic   on;
        wt_st_e st;
        logic   hist;
    } wait_s;

    wait_s q, d;
    logic  to_active;

    always_comb begin
        d         = q;
        to_active = q.on & wake_i;
        if (q.on) begin
            if (wake_i) begin
                d.hist = (q.st == WT_BG);
                d.st   = WT_ENTRY;
                d.on   = 1'b0;
            end else if (bg_i) begin
                d.st = (q.st == WT_BG) ? WT_IDLE : WT_BG;
            end
        end else if (to_wait_i) begin
            d.st = q.hist ? WT_BG : WT_IDLE;
            d.on = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.on   <= 1'b1;
            q.st   <= WT_IDLE;
            q.hist <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign on_o        = q.on;
    assign bg_raw_o    = (q.st == WT_BG);
    assign to_active_o = to_active;

    AST_WAIT_ENTRY_MATCH: assert property (@(posedge clk) disable iff (rst)
        q.on == (q.st != WT_ENTRY)); // R4

    AST_WAKE_SAVES_HIST: assert property (@(posedge clk) disable iff (rst)
        (q.on && wake_i) |=> (!q.on && q.hist == ($past(q.st) == WT_BG))); // R6

    AST_RESUME_FROM_HIST: assert property (@(posedge clk) disable iff (rst)
        (!q.on && to_wait_i) |=> (q.on && ((q.st == WT_BG) == $past(q.hist)))); // R4

    AST_OFF_HOLDS_HIST: assert property (@(posedge clk) disable iff (rst)
        (!q.on && !to_wait_i) |=> $stable(q.hist)); // R4

endmodule

// File: rtl/hsc_send_region.sv
module hsc_send_region
    import hsc_pkg::*;
#(
    parameter int TX_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic to_active_i,
    input  logic sleep_i,
    input  logic tx_req_i,
    output logic on_o,
    output logic busy_raw_o,
    output logic done_o,
    output logic to_wait_o
);

    localparam int CNT_W = (TX_CYCLES > 1) ? $clog2(TX_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TX_CYCLES - 1);

    typedef struct packed {
        logic             on;
        snd_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } send_s;

    send_s q, d;
    logic  to_wait;
    logic  done;

    always_comb begin
        d       = q;
        to_wait = q.on & sleep_i;
        done    = q.on && (q.st == SND_BUSY) && (q.cnt == '0);
        if (!q.on) begin
            if (to_active_i) begin
                d.on   = 1'b1;
                d.st   = SND_READY;
                d.cnt  = '0;
                d.pend = 1'b0;
            end
        end else if (to_wait) begin
            d.on   = 1'b0;
            d.st   = SND_READY;
            d.cnt  = '0;
            d.pend = 1'b0;
        end else begin
            case (q.st)
                SND_READY: begin
                    if (tx_req_i) begin
                        d.st  = SND_BUSY;
                        d.cnt = CNT_LAST;
                    end
                end
                SND_BUSY: begin
                    if (q.cnt == '0) begin
                        if (q.pend || tx_req_i) begin
                            d.cnt  = CNT_LAST;
                            d.pend = 1'b0;
                        end else begin
                            d.st = SND_READY;
                        end
                    end else begin
                        d.cnt  = q.cnt - 1'b1;
                        d.pend = q.pend | tx_req_i;
                    end
                end
                default: d.st = SND_READY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.on   <= 1'b0;
            q.st   <= SND_READY;
            q.cnt  <= '0;
            q.pend <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign on_o       = q.on;
    assign busy_raw_o = (q.st == SND_BUSY);
    assign done_o     = done;
    assign to_wait_o  = to_wait;

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        (q.on && q.st == SND_READY && tx_req_i && !sleep_i) |=>
            (q.st == SND_BUSY && q.cnt == CNT_LAST)); // R7

    AST_PEND_RESTART: assert property (@(posedge clk) disable iff (rst)
        (q.on && q.st == SND_BUSY && q.cnt == '0 && q.pend && !sleep_i) |=>
            (q.st == SND_BUSY && !q.pend)); // R8

    AST_SLEEP_ABORTS: assert property (@(posedge clk) disable iff (rst)
        to_wait |=> (!q.on && q.st == SND_READY && !q.pend)); // R11

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !q.on |-> (q.st == SND_READY && !q.pend)); // R11

endmodule

// File: rtl/hsc_recv_region.sv
module hsc_recv_region
    import hsc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic to_active_i,
    input  logic to_wait_i,
    input  logic rx_i,
    output logic on_o,
    output logic save_raw_o
);

    typedef struct packed {
        logic    on;
        rcv_st_e st;
    } recv_s;

    recv_s q, d;

    always_comb begin
        d = q;
        if (!q.on) begin
            if (to_active_i) begin
                d.on = 1'b1;
                d.st = RCV_LISTEN;
            end
        end else if (to_wait_i) begin
            d.on = 1'b0;
            d.st = RCV_LISTEN;
        end else begin
            case (q.st)
                RCV_LISTEN: if (rx_i) d.st = RCV_SAVE;
                RCV_SAVE:   d.st = RCV_LISTEN;
                default:    d.st = RCV_LISTEN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.on <= 1'b0;
            q.st <= RCV_LISTEN;
        end else begin
            q <= d;
        end
    end

    assign on_o       = q.on;
    assign save_raw_o = (q.st == RCV_SAVE);

    AST_SAVE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (q.st == RCV_SAVE) |=> (q.st == RCV_LISTEN)); // R9

    AST_SAVE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(q.st == RCV_SAVE) |-> $past(rx_i && q.on && !to_wait_i)); // R6

endmodule

// File: rtl/hsc_merge.sv
module hsc_merge #(
    parameter int N = 3
) (
    input  logic [N-1:0] sig_i,
    input  logic [N-1:0] act_i,
    output logic         out_o
);

    logic [N-1:0] gated;

    for (genvar g = 0; g < N; g++) begin : g_gate
        assign gated[g] = sig_i[g] & act_i[g];
    end

    assign out_o = |gated;

endmodule

// File: rtl/hsc_ctrl.sv
module hsc_ctrl
    import hsc_pkg::*;
#(
    parameter int TX_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic wake_i,
    input  logic sleep_i,
    input  logic bg_i,
    input  logic tx_req_i,
    input  logic rx_data_i,
    output logic send_on_o,
    output logic recv_on_o,
    output logic wait_on_o,
    output logic wait_bg_o,
    output logic tx_busy_o,
    output logic tx_done_o,
    output logic save_o,
    output logic work_o
);

    logic ev_to_active;
    logic ev_to_wait;
    logic send_on, recv_on, wait_on;
    logic send_busy_raw, send_done, recv_save_raw, wait_bg_raw;
    logic [NUM_REG-1:0] reg_sig, reg_act;

    hsc_wait_region u_wait (
        .clk         (clk),
        .rst         (rst),
        .wake_i      (wake_i),
        .bg_i        (bg_i),
        .to_wait_i   (ev_to_wait),
        .on_o        (wait_on),
        .bg_raw_o    (wait_bg_raw),
        .to_active_o (ev_to_active)
    );

    hsc_send_region #(.TX_CYCLES(TX_CYCLES)) u_send (
        .clk         (clk),
        .rst         (rst),
        .to_active_i (ev_to_active),
        .sleep_i     (sleep_i),
        .tx_req_i    (tx_req_i),
        .on_o        (send_on),
        .busy_raw_o  (send_busy_raw),
        .done_o      (send_done),
        .to_wait_o   (ev_to_wait)
    );

    hsc_recv_region u_recv (
        .clk         (clk),
        .rst         (rst),
        .to_active_i (ev_to_active),
        .to_wait_i   (ev_to_wait),
        .rx_i        (rx_data_i),
        .on_o        (recv_on),
        .save_raw_o  (recv_save_raw)
    );

    assign reg_sig[REG_SEND] = send_busy_raw;
    assign reg_sig[REG_RECV] = recv_save_raw;
    assign reg_sig[REG_WAIT] = wait_bg_raw;
    assign reg_act[REG_SEND] = send_on;
    assign reg_act[REG_RECV] = recv_on;
    assign reg_act[REG_WAIT] = wait_on;

    hsc_merge #(.N(NUM_REG)) u_merge (
        .sig_i (reg_sig),
        .act_i (reg_act),
        .out_o (work_o)
    );

    assign send_on_o = send_on;
    assign recv_on_o = recv_on;
    assign wait_on_o = wait_on;
    assign wait_bg_o = wait_bg_raw & wait_on;
    assign tx_busy_o = send_busy_raw & send_on;
    assign tx_done_o = send_done;
    assign save_o    = recv_save_raw & recv_on;

    AST_ONE_SUPERSTATE: assert property (@(posedge clk) disable iff (rst)
        (send_on_o == recv_on_o) && (send_on_o != wait_on_o)); // R2

    AST_WAKE_ENTERS: assert property (@(posedge clk) disable iff (rst)
        (wait_on_o && wake_i) |=> (send_on_o && recv_on_o && !tx_busy_o && !save_o)); // R2

    AST_SLEEP_LEAVES: assert property (@(posedge clk) disable iff (rst)
        (send_on_o && sleep_i) |=> (wait_on_o && !tx_busy_o && !save_o)); // R3

    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        tx_done_o |-> tx_busy_o); // R7

    AST_WORK_MERGE: assert property (@(posedge clk) disable iff (rst)
        work_o == (tx_busy_o || save_o || wait_bg_o)); // R10

    AST_BG_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (wait_on_o && bg_i && !wake_i) |=> (wait_on_o && wait_bg_o != $past(wait_bg_o))); // R5

endmodule

// File: tb/hsc_ctrl_test.sv
`timescale 1ns/1ps
module hsc_ctrl_test;

    localparam int TX = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wake = 1'b0, sleep = 1'b0, bg = 1'b0, txr = 1'b0, rxd = 1'b0;
    logic send_on, recv_on, wait_on, wait_bg, tx_busy, tx_done, save, work;

    always #2 clk = ~clk;

    hsc_ctrl #(.TX_CYCLES(TX)) uut (
        .clk       (clk),
        .rst       (rst),
        .wake_i    (wake),
        .sleep_i   (sleep),
        .bg_i      (bg),
        .tx_req_i  (txr),
        .rx_data_i (rxd),
        .send_on_o (send_on),
        .recv_on_o (recv_on),
        .wait_on_o (wait_on),
        .wait_bg_o (wait_bg),
        .tx_busy_o (tx_busy),
        .tx_done_o (tx_done),
        .save_o    (save),
        .work_o    (work)
    );

    // behavioural reference state
    int    m_act, m_bg, m_hist, m_left, m_pend, m_save;
    int    vectors = 0, errors = 0;
    bit    finished = 0;
    string tag = "R1";

    function automatic void model_reset();
        m_act = 0; m_bg = 0; m_hist = 0; m_left = 0; m_pend = 0; m_save = 0;
    endfunction

    function automatic void model_step();
        if (m_act == 0) begin
            if (wake) begin
                m_hist = m_bg; m_act = 1; m_left = 0; m_pend = 0; m_save = 0;
            end else if (bg) begin
                m_bg = 1 - m_bg;
            end
        end else if (sleep) begin
            m_act = 0; m_bg = m_hist; m_left = 0; m_pend = 0; m_save = 0;
        end else begin
            if (m_left == 0) begin
                if (txr) m_left = TX;
            end else if (m_left == 1) begin
                if (m_pend != 0 || txr) begin m_left = TX; m_pend = 0; end
                else m_left = 0;
            end else begin
                m_left = m_left - 1;
                if (txr) m_pend = 1;
            end
            if (m_save != 0) m_save = 0;
            else if (rxd) m_save = 1;
        end
    endfunction

    task automatic cmp(string name, logic act, int exp);
        if (act !== logic'(exp != 0)) begin
            errors++;
            $display("FAIL %s %s: got %b expected %0d at %0t", tag, name, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int e_busy, e_done, e_wbg, e_save;
        e_busy = (m_act != 0 && m_left > 0) ? 1 : 0;
        e_done = (m_act != 0 && m_left == 1) ? 1 : 0;
        e_wbg  = (m_act == 0 && m_bg != 0) ? 1 : 0;
        e_save = (m_act != 0 && m_save != 0) ? 1 : 0;
        vectors++;
        cmp("send_on", send_on, m_act);
        cmp("recv_on", recv_on, m_act);
        cmp("wait_on", wait_on, (m_act == 0) ? 1 : 0);
        cmp("wait_bg", wait_bg, e_wbg);
        cmp("tx_busy", tx_busy, e_busy);
        cmp("tx_done", tx_done, e_done);
        cmp("save", save, e_save);
        cmp("work", work, (e_busy | e_save | e_wbg));
    endtask

    // one cycle: set pulses after a falling edge, step at the rising edge, compare at the next falling edge
    task automatic cyc(logic w, logic s, logic b, logic t, logic r);
        wake = w; sleep = s; bg = b; txr = t; rxd = r;
        @(posedge clk);
        #0.1;
        model_step();
        @(negedge clk);
        wake = 0; sleep = 0; bg = 0; txr = 0; rxd = 0;
        compare_all();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tag = "R1";  compare_all(); idle(2);
        tag = "R5";  cyc(0, 0, 1, 0, 0); idle(1); cyc(0, 0, 1, 0, 0); cyc(0, 0, 1, 0, 0);
        tag = "R2";  cyc(1, 0, 0, 0, 0); idle(2);
        tag = "R10"; idle(1);
        tag = "R3";  cyc(1, 0, 0, 0, 0); cyc(0, 0, 1, 0, 0); idle(1);
        tag = "R4";  cyc(0, 1, 0, 0, 0); idle(1);
        tag = "R3";  cyc(0, 1, 0, 0, 0); idle(1);
        tag = "R4";  cyc(0, 0, 1, 0, 0); cyc(1, 0, 0, 0, 0); idle(2);
                     cyc(0, 1, 0, 0, 0); idle(1); cyc(1, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0);
        tag = "R6";  cyc(0, 0, 1, 0, 0); cyc(1, 0, 1, 0, 0); idle(1);
                     cyc(0, 1, 0, 1, 1); idle(2);
                     cyc(1, 0, 0, 0, 0);
        tag = "R7";  cyc(0, 0, 0, 1, 0); idle(TX + 2);
        tag = "R8";  cyc(0, 0, 0, 1, 0); cyc(0, 0, 0, 1, 0); cyc(0, 0, 0, 1, 0); idle(2 * TX + 2);
                     cyc(0, 0, 0, 1, 0); idle(TX - 1); cyc(0, 0, 0, 1, 0); idle(TX + 1);
        tag = "R9";  cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 1); idle(1); cyc(0, 0, 0, 0, 1); idle(2);
        tag = "R11"; cyc(0, 0, 0, 1, 0); cyc(0, 0, 0, 1, 0); cyc(0, 1, 0, 0, 0); idle(2);
                     cyc(1, 0, 0, 0, 0); idle(TX + 2);
        tag = "R1";  rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0; model_reset();
                     compare_all(); cyc(1, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0);
        tag = "R10";
        for (int i = 0; i < 4000; i++) begin
            int unsigned v;
            v = $urandom;
            cyc(v[3:0] == 0, v[7:4] == 0, v[10:8] == 0, v[12:11] == 0, v[14:13] == 0);
        end
        finish_run();
    end

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule